// File: doc/BRIEF.md
# Mains-Referenced One-Second Pulse Generator

This block produces a once-per-second timing pulse from the 50 Hz square wave that is shaped from the AC supply. A fast system clock oversamples the active-low mains clock. The block detects the falling edges of that clock and counts them in a six-stage binary divider. The divider is cleared when it reaches a terminal count of fifty. That count is recognised only from the three stages that are set at fifty, with weights 32, 16 and 2. The decode sets a set-reset latch. The latch both clears the divider and forms the one-second output pulse, which is active low. The latch releases one system clock after the divider reads zero, so every pulse lasts exactly two system clocks.

A master-clear signal comes from two sources: a power-on timer that runs after a synchronous power-up reset, and a debounced push button. While master clear is high, the gated mains clock is held at its inactive high level, the divider is held at zero and no pulse is produced. Master clear, the gated mains clock and the pulse output are the three signals passed on to the later timekeeping stages.

Top module: `pps_prescaler`

## Requirements
- R1: While `rst_pwr` is high, `mclr` is high. After `rst_pwr` falls, `mclr` stays high for exactly POR_CYCLES rising clock edges and then goes low, provided the button is released.
- R2: `mclr` is high in every cycle in which `btn_clr` is high.
- R3: While `mclr` is high, `mains_gated_n` is 1. Otherwise `mains_gated_n` equals `mains_n` delayed by SYNC_STAGES (default 2) rising clock edges.
- R4: Each falling edge of `mains_gated_n` advances the divider by exactly one count, and one falling edge gives exactly one count.
- R5: `pps_n` pulses once for every TERM_COUNT (default 50) falling mains edges counted since the divider was last cleared. The next count then starts from zero.
- R6: `pps_n` is active low, and each pulse holds it low for exactly two consecutive system clocks.
- R7: Master clear clears the divider and the latch. No pulse occurs while it is held, and after it is released a full TERM_COUNT edges are needed before the next pulse.
- R8: The divider never exceeds TERM_COUNT. The terminal count is decoded from the stages that are set in TERM_COUNT and from no others, and no pulse appears after fewer than TERM_COUNT edges.
- R9: Counting rising clock edges from the one on which `mains_n` is first sampled low, `pps_n` goes low after the fourth edge and returns high after the sixth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the mains clock |
| rst_pwr | input | 1 | Synchronous power-up reset, active high |
| btn_clr | input | 1 | Debounced clear button, high while pressed, synchronous to clk |
| mains_n | input | 1 | Active-low 50 Hz mains-derived clock, asynchronous |
| mclr | output | 1 | Master clear, active high |
| mains_gated_n | output | 1 | Synchronised mains clock, forced high during master clear |
| pps_n | output | 1 | Active-low one-second pulse |

## Verification
The assertions assume that the mains clock stays in each level for many system clocks. Under that assumption, a new falling edge never arrives during the two-clock pulse or while the divider is being cleared, and the divider cannot step past fifty. They also assume that the button is synchronous and debounced. The stimulus holds each mains level for ten system clocks. It changes the button and the power reset only on a falling clock edge while the mains clock is high, so a master-clear release never creates a false falling edge.

// File: rtl/ppsp_pkg.sv
package ppsp_pkg;
   // Width needed to hold values 0..v inclusive
   function automatic int unsigned span_bits(input int unsigned v);
      int unsigned w;
      w = 1;
      while ((64'd1 << w) <= v) w++;
      return w;
   endfunction

   // Stages that take part in the terminal decode
   typedef enum logic {
      DECODE_FULL    = 1'b0,
      DECODE_SET_BITS = 1'b1
   } decode_mode_e;
endpackage

// File: rtl/ppsp_por_timer.sv
module ppsp_por_timer #(
   parameter int unsigned POR_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_pwr,
   input  logic btn_clr,
   output logic mclr
);
   localparam int unsigned CW = ppsp_pkg::span_bits(POR_CYCLES);

   if (POR_CYCLES < 1) begin : g_bad_por
      $error("POR_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   always_ff @(posedge clk) begin
      if (rst_pwr) begin
         cnt_q  <= '0;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == CW'(POR_CYCLES - 1)) busy_q <= 1'b0;
      end
   end

   assign mclr = busy_q | btn_clr;

   AST_POR_STAYS_DONE: assert property (@(posedge clk) disable iff (rst_pwr)
      !busy_q |=> !busy_q); // R1
   AST_POR_BOUNDED: assert property (@(posedge clk) disable iff (rst_pwr)
      busy_q |-> (cnt_q < CW'(POR_CYCLES))); // R1
endmodule

// File: rtl/ppsp_mains_sync.sv
module ppsp_mains_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_pwr,
   input  logic mclr,
   input  logic mains_n,
   output logic gated_n,
   output logic fall
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] chain_q;
   logic                   prev_q;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst_pwr) chain_q[0] <= 1'b1;
            else         chain_q[0] <= mains_n;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst_pwr) chain_q[i] <= 1'b1;
            else         chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign gated_n = mclr | chain_q[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (rst_pwr) prev_q <= 1'b1;
      else         prev_q <= gated_n;
   end

   assign fall = prev_q & ~gated_n;

   AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst_pwr)
      fall |=> !fall); // R4
endmodule

// File: rtl/ppsp_divider.sv
module ppsp_divider #(
   parameter int unsigned STAGES     = 6,
   parameter int unsigned TERM_COUNT = 50,
   parameter ppsp_pkg::decode_mode_e DECODE = ppsp_pkg::DECODE_SET_BITS
) (
   input  logic              clk,
   input  logic              rst_pwr,
   input  logic              clr,
   input  logic              step,
   output logic [STAGES-1:0] count,
   output logic              term_hit
);
   localparam logic [STAGES-1:0] MASK = STAGES'(TERM_COUNT);

   if (TERM_COUNT < 1 || TERM_COUNT >= (1 << STAGES)) begin : g_bad_term
      $error("TERM_COUNT must fit in STAGES bits and be non-zero");
   end

   logic [STAGES:0] carry;
   assign carry[0] = step;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      assign carry[i+1] = carry[i] & count[i];
      always_ff @(posedge clk) begin
         if (rst_pwr || clr) count[i] <= 1'b0;
         else if (carry[i])  count[i] <= ~count[i];
      end
   end

   if (DECODE == ppsp_pkg::DECODE_SET_BITS) begin : g_dec_sparse
      assign term_hit = &(count | ~MASK);
   end else begin : g_dec_full
      assign term_hit = (count == MASK);
   end

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst_pwr)
      count <= MASK); // R8
   AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst_pwr)
      (step && !clr) |=> (count == STAGES'($past(count) + 1'b1))); // R4
endmodule

// File: rtl/ppsp_pulse_latch.sv
module ppsp_pulse_latch (
   input  logic clk,
   input  logic rst_pwr,
   input  logic mclr,
   input  logic set,
   input  logic count_zero,
   output logic q
);
   always_ff @(posedge clk) begin
      if (rst_pwr || mclr)         q <= 1'b0;
      else if (set)                q <= 1'b1;
      else if (q && count_zero)    q <= 1'b0;
   end

   AST_PULSE_MAX_TWO: assert property (@(posedge clk) disable iff (rst_pwr)
      (q && $past(q)) |=> !q); // R6
   AST_PULSE_MIN_TWO: assert property (@(posedge clk) disable iff (rst_pwr)
      $rose(q) |=> (q || mclr)); // R6
endmodule

// File: rtl/pps_prescaler.sv
module pps_prescaler #(
   parameter int unsigned POR_CYCLES  = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DIV_STAGES  = 6,
   parameter int unsigned TERM_COUNT  = 50,
   parameter ppsp_pkg::decode_mode_e DECODE = ppsp_pkg::DECODE_SET_BITS
) (
   input  logic clk,
   input  logic rst_pwr,
   input  logic btn_clr,
   input  logic mains_n,
   output logic mclr,
   output logic mains_gated_n,
   output logic pps_n
);
   logic                  fall;
   logic                  latch_q;
   logic                  term_hit;
   logic [DIV_STAGES-1:0] count;

   ppsp_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
      .clk(clk), .rst_pwr(rst_pwr), .btn_clr(btn_clr), .mclr(mclr)
   );

   ppsp_mains_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_pwr(rst_pwr), .mclr(mclr), .mains_n(mains_n),
      .gated_n(mains_gated_n), .fall(fall)
   );

   ppsp_divider #(.STAGES(DIV_STAGES), .TERM_COUNT(TERM_COUNT), .DECODE(DECODE)) u_div (
      .clk(clk), .rst_pwr(rst_pwr), .clr(mclr | latch_q), .step(fall),
      .count(count), .term_hit(term_hit)
   );

   ppsp_pulse_latch u_latch (
      .clk(clk), .rst_pwr(rst_pwr), .mclr(mclr), .set(term_hit),
      .count_zero(count == '0), .q(latch_q)
   );

   assign pps_n = ~latch_q;

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst_pwr)
      mclr |=> (count == '0 && pps_n)); // R7
   AST_CLEAR_GATES: assert property (@(posedge clk) disable iff (rst_pwr)
      btn_clr |-> (mclr && mains_gated_n)); // R2
endmodule

// File: tb/pps_prescaler_bench.sv
module pps_prescaler_bench;
   localparam int unsigned POR = 16;
   localparam int unsigned TERM = 50;
   localparam int NROWS = 9;
   // each row: mains cycles, button held, expected pulses in the row
   localparam int unsigned VEC [0:NROWS-1][0:2] = '{
      '{50, 0, 1}, '{49, 0, 0}, '{1, 0, 1}, '{100, 0, 2}, '{30, 1, 0},
      '{50, 0, 1}, '{20, 0, 0}, '{5, 1, 0}, '{50, 0, 1}
   };

   logic clk = 1'b0;
   logic rst_pwr = 1'b1;
   logic btn_clr = 1'b0;
   logic mains_n = 1'b1;
   logic mclr, mains_gated_n, pps_n;

   int checks = 0;
   int failures = 0;
   int ref_cnt = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pps_prescaler #(.POR_CYCLES(POR), .TERM_COUNT(TERM)) u_pps_prescaler (
      .clk(clk), .rst_pwr(rst_pwr), .btn_clr(btn_clr), .mains_n(mains_n),
      .mclr(mclr), .mains_gated_n(mains_gated_n), .pps_n(pps_n)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one mains period: low 10 clocks then high 10 clocks; returns 1 if a pulse was seen
   task automatic mains_cycle(output bit pulsed);
      logic [7:0] got;
      logic [1:0] g;
      bit exp_p;
      exp_p = 1'b0;
      if (btn_clr) ref_cnt = 0;
      else begin
         ref_cnt++;
         if (ref_cnt == TERM) begin exp_p = 1'b1; ref_cnt = 0; end
      end
      @(negedge clk) mains_n = 1'b0;
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         got[k-1] = pps_n;
         if (k <= 2) g[2-k] = mains_gated_n;
      end
      check(got == (exp_p ? 8'hE7 : 8'hFF), "R5 R6 R9 pulse pattern", got, exp_p ? 8'hE7 : 8'hFF);
      check(g == (btn_clr ? 2'b11 : 2'b10), "R3 gated mains", g, btn_clr ? 2'b11 : 2'b10);
      repeat (2) @(negedge clk);
      mains_n = 1'b1;
      repeat (10) @(negedge clk);
      check(pps_n == 1'b1, "R6 idle high", pps_n, 1);
      pulsed = (got != 8'hFF);
   endtask

   task automatic por_check();
      int hi_at_last;
      rst_pwr = 1'b1;
      repeat (3) @(negedge clk);
      check(mclr && mains_gated_n && pps_n, "R1 reset state", {mclr, mains_gated_n, pps_n}, 3'b111);
      rst_pwr = 1'b0;
      for (int k = 1; k <= POR; k++) begin
         @(negedge clk);
         if (k == POR - 1) hi_at_last = mclr;
      end
      check(hi_at_last == 1 && mclr == 1'b0, "R1 power-on length", {hi_at_last[0], mclr}, 2'b10);
      ref_cnt = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      bit p;
      int pulses;
      por_check();
      for (int r = 0; r < NROWS; r++) begin
         @(negedge clk) btn_clr = VEC[r][1][0];
         if (btn_clr) begin
            @(negedge clk);
            check(mclr == 1'b1, "R2 button forces clear", mclr, 1);
            ref_cnt = 0;
         end
         pulses = 0;
         for (int c = 0; c < int'(VEC[r][0]); c++) begin
            mains_cycle(p);
            pulses += int'(p);
         end
         check(pulses == int'(VEC[r][2]), "R5 R7 R8 row pulse total", pulses, VEC[r][2]);
      end
      @(negedge clk) btn_clr = 1'b0;

      // power reset in mid-count: counting restarts from zero (R7, R1)
      for (int c = 0; c < 30; c++) mains_cycle(p);
      por_check();
      pulses = 0;
      for (int c = 0; c < 49; c++) begin mains_cycle(p); pulses += int'(p); end
      check(pulses == 0, "R8 no early pulse after power reset", pulses, 0);
      mains_cycle(p);
      check(p == 1'b1, "R4 fiftieth edge pulses", p, 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule